// File: doc/BRIEF.md
# Write Pointer Report Coalescer

This block decides when a ring's current write pointer is sent to its consumer. It does not report on every new entry. It counts the entries written since the last report and issues one report pulse when that count reaches a programmable threshold. It also issues a report when a programmable timer runs out while entries are still waiting. The pulse carries the write pointer present on the input in that cycle. A downstream agent turns the pulse into an interrupt or a memory writeback.

Both limits are programmed as exponents. A threshold code `t` gives a limit of 2^t entries. A timeout code `k` gives a limit of 2^k × 2^`TMO_SCALE_LOG2` clock cycles, which is 2^k × 1024 cycles at the default setting. Software normally uses a threshold code of 0 and a timeout code of 8. A separate enable turns the timeout path on or off. The threshold path is always active.

Top module: `wptr_report_coalescer`

## Requirements
- R1: While reset is active and after it is released, with no entries, `report_pulse` is 0 and `report_wptr` is 0.
- R2: With `thr_code` = 0, every accepted entry produces a report pulse on the clock edge that accepts it. `report_wptr` then equals the `wptr_in` of that cycle.
- R3: With `thr_code` = t, a report pulse appears on the edge that accepts the 2^t-th pending entry, and it carries that cycle's `wptr_in`. Earlier entries produce no pulse.
- R4: With `tmo_enable` = 1 and entries pending, a report pulse appears exactly 2^code × 2^`TMO_SCALE_LOG2` cycles after the edge that accepted the first pending entry. It carries the `wptr_in` present just before that edge.
- R5: With `tmo_enable` = 0, pending entries below the threshold produce no report, however long they wait. They stay counted toward the threshold.
- R6: When the threshold and the timeout are reached on the same edge, exactly one report pulse is produced. No further report follows unless a new entry arrives.
- R7: A `tmo_code` above `TMO_CODE_MAX` (default 20) behaves exactly like `TMO_CODE_MAX`.
- R8: After any report, the timeout is measured again from the first entry accepted after that report.
- R9: The pending count returns to zero on every report. An entry accepted on the report edge counts toward that report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_pulse | input | 1 | One-cycle pulse for each new ring entry |
| wptr_in | input | PTR_W | Current ring write pointer |
| thr_code | input | THR_CODE_W | Threshold exponent: the limit is 2^thr_code entries |
| tmo_code | input | TMO_CODE_W | Timeout exponent, clamped to TMO_CODE_MAX |
| tmo_enable | input | 1 | Enables reports forced by the timeout |
| report_pulse | output | 1 | One-cycle report strobe |
| report_wptr | output | PTR_W | Write pointer captured with the last report |

## Verification
The bench first drives single entries with a threshold code of 0, which shows whether reporting is immediate. It then sends bursts against a threshold of 4, with the timer off. These bursts show whether the count reaches the exact threshold, whether it restarts after a report, and whether waiting entries survive a long idle period. Sparse entries below a large threshold, tried with timeout codes 0, 1 and an out-of-range code, separate a correct exponent, scale and clamp from off-by-one timer starts. Finally, one entry is placed so that it lands on the exact edge where the timeout expires. This shows whether the two triggers merge into one pulse and leave no stray report behind.

// File: rtl/wptr_report_coalescer.sv
module wptr_report_coalescer #(
  parameter int PTR_W          = 16,
  parameter int THR_CODE_W     = 4,
  parameter int TMO_CODE_W     = 5,
  parameter int TMO_CODE_MAX   = 20,
  parameter int TMO_SCALE_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  entry_pulse,
  input  logic [PTR_W-1:0]      wptr_in,
  input  logic [THR_CODE_W-1:0] thr_code,
  input  logic [TMO_CODE_W-1:0] tmo_code,
  input  logic                  tmo_enable,
  output logic                  report_pulse,
  output logic [PTR_W-1:0]      report_wptr
);
  localparam int CW = 1 << THR_CODE_W;
  localparam int TW = TMO_CODE_MAX + TMO_SCALE_LOG2 + 1;

  logic [CW-1:0]         pend_cnt, cnt_nx, thr_val;
  logic [TW-1:0]         timer, tmo_lim;
  logic [TMO_CODE_W-1:0] code_c;
  logic                  thr_hit, tmo_hit, fire;

  assign thr_val = CW'(1) << thr_code;
  assign code_c  = (32'(tmo_code) > TMO_CODE_MAX) ? TMO_CODE_W'(TMO_CODE_MAX) : tmo_code;
  assign tmo_lim = TW'(1) << (32'(code_c) + TMO_SCALE_LOG2);
  assign cnt_nx  = pend_cnt + CW'(entry_pulse);
  assign thr_hit = (cnt_nx != '0) && (cnt_nx >= thr_val);
  assign tmo_hit = tmo_enable && (pend_cnt != '0) && (timer >= tmo_lim - TW'(1));
  assign fire    = thr_hit | tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt     <= '0;
      timer        <= '0;
      report_pulse <= 1'b0;
      report_wptr  <= '0;
    end else begin
      report_pulse <= fire;
      if (fire) report_wptr <= wptr_in;
      pend_cnt <= fire ? '0 : cnt_nx;
      if (fire || pend_cnt == '0) timer <= '0;
      else if (timer != '1)       timer <= timer + TW'(1);
    end
  end

  // R3
  thr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt < $past(thr_val));

  // R2
  immediate_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && thr_code == '0) |=> (report_pulse && report_wptr == $past(wptr_in)));

  // R4
  tmo_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_enable && pend_cnt != '0 && timer >= tmo_lim - TW'(1)) |=> report_pulse);

  // R5
  tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_enable && !entry_pulse && pend_cnt < thr_val) |=> !report_pulse);

  // R8
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer != '0) |-> (pend_cnt != '0));

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    report_pulse |-> (pend_cnt == '0 && timer == '0));
endmodule

// File: tb/wptr_report_coalescer_tb.sv
module wptr_report_coalescer_tb;
  localparam int LIM0 = 1024;

  typedef struct {
    int unsigned cyc;
    logic [15:0] w;
    string       req;
  } exp_t;

  logic        clk = 0, rst_n = 0, entry_pulse = 0, tmo_enable = 0;
  logic [15:0] wptr_in = '0;
  logic [3:0]  thr_code = '0;
  logic [4:0]  tmo_code = '0;
  logic        report_pulse;
  logic [15:0] report_wptr;

  int unsigned cyc = 0;
  int          errs = 0, checks = 0;
  bit          done = 0;
  exp_t        exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wptr_report_coalescer #(.PTR_W(16), .TMO_CODE_MAX(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .entry_pulse(entry_pulse), .wptr_in(wptr_in),
    .thr_code(thr_code), .tmo_code(tmo_code), .tmo_enable(tmo_enable),
    .report_pulse(report_pulse), .report_wptr(report_wptr));

  always @(negedge clk) begin
    if (rst_n && report_pulse) begin
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL unexpected report: cyc=%0d wptr=%h expected none", cyc, report_wptr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.cyc != cyc || e.w != report_wptr) begin
          errs++;
          $display("FAIL %s: report cyc=%0d wptr=%h expected cyc=%0d wptr=%h",
                   e.req, cyc, report_wptr, e.cyc, e.w);
        end
      end
    end
  end

  task automatic send(input logic [15:0] w, input bit rep, input string req,
                      output int unsigned acc);
    acc = cyc + 1;
    if (rep) exp_q.push_back('{acc, w, req});
    entry_pulse = 1; wptr_in = w;
    @(negedge clk);
    entry_pulse = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet_check(input string req);
    checks++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL %s: %0d expected report(s) missing, expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int unsigned a, b;
    idle(3);
    checks++;
    if (report_pulse !== 1'b0 || report_wptr !== 16'h0) begin
      errs++;
      $display("FAIL R1: pulse=%b wptr=%h expected 0/0000", report_pulse, report_wptr);
    end
    rst_n = 1;
    idle(4);
    checks++;
    if (report_pulse !== 1'b0 || report_wptr !== 16'h0) begin
      errs++;
      $display("FAIL R1: after release pulse=%b wptr=%h expected 0/0000", report_pulse, report_wptr);
    end

    // R2: threshold code 0 reports each entry
    for (int i = 0; i < 3; i++) begin
      send(16'h0100 + 16'(i), 1, "R2", a);
      idle(2);
    end
    quiet_check("R2");

    // R3: threshold of 4 entries, timer off
    thr_code = 4'd2;
    for (int i = 0; i < 4; i++) begin
      send(16'h0200 + 16'(i), i == 3, "R3", a);
      idle(3);
    end
    quiet_check("R3");
    // R9 and R5: count restarts; three pending entries wait with no timeout
    for (int i = 0; i < 3; i++) begin
      send(16'h0210 + 16'(i), 0, "R9", a);
      idle(1);
    end
    idle(3000);
    quiet_check("R5");
    send(16'h0220, 1, "R9", a);
    idle(3);
    quiet_check("R9");

    // R4: timeout code 0 measured from the first pending entry
    thr_code = 4'd4; tmo_code = 5'd0; tmo_enable = 1;
    send(16'h0300, 0, "R4", a);
    idle(4);
    send(16'h0301, 0, "R4", b);
    exp_q.push_back('{a + LIM0, 16'h0301, "R4"});
    idle(1100);
    quiet_check("R4");

    // R8: timer restarts from the first entry after the report
    send(16'h0302, 0, "R8", a);
    exp_q.push_back('{a + LIM0, 16'h0302, "R8"});
    idle(1100);
    quiet_check("R8");

    // R4: timeout code 1
    tmo_code = 5'd1;
    send(16'h0600, 0, "R4", a);
    exp_q.push_back('{a + 2 * LIM0, 16'h0600, "R4"});
    idle(2200);
    quiet_check("R4");

    // R6: threshold and timeout on the same edge
    thr_code = 4'd1; tmo_code = 5'd0;
    send(16'h0400, 0, "R6", a);
    while (cyc != a + LIM0 - 1) @(negedge clk);
    send(16'h0401, 1, "R6", b);
    idle(5);
    quiet_check("R6");
    idle(1100);
    quiet_check("R6");

    // R7: out-of-range code clamps to the maximum (2 in this bench)
    thr_code = 4'd4; tmo_code = 5'd31;
    send(16'h0500, 0, "R7", a);
    exp_q.push_back('{a + 4 * LIM0, 16'h0500, "R7"});
    idle(4200);
    quiet_check("R7");

    finish_run();
  end
endmodule